// File: doc/BRIEF.md
# Baud Clock Recovery Loop

This block recovers a baud-rate sampling strobe for a line receiver. It runs on a 15.36 MHz master clock, which gives 80 clocks per nominal symbol. It takes one-cycle pulses marking the transitions of the sliced receive signal. A phase counter defines the local symbol period. The counter returns to phase 0 at each boundary and the strobe is placed near mid-symbol.

A mode input selects how the phase is set. In adaptive mode, each incoming transition votes "late" or "early" according to where it lands in the local period. Once enough net votes gather on one side, a single period is stretched or shrunk by one clock. In fixed mode, the counter restarts on every pulse of the local transmit baud tick, and the strobe fires a programmable number of clocks after the boundary. Received transitions then do not move the phase.

The block also produces a recovered baud clock and a lock flag. The baud clock can time the downstream interface. A new mode value is taken only at a period boundary.

Top module: `baud_rec_dpll`

## Requirements
- R1: While `rst` is high at a clock edge, `samp_stb`, `baud_clk` and `locked` are 0 after that edge.
- R2: In fixed mode (`mode_adapt`=0), the clock edge that samples `tx_tick` high starts a new period, so `baud_clk` goes high in the following cycle. `samp_stb` then pulses exactly `fix_offset` cycles after that rise, which is `fix_offset`+1 cycles after the sampling edge, for `fix_offset` in 0..78. In this mode `rx_edge` pulses do not move the strobe.
- R3: `samp_stb` is one cycle wide. Every period of the phase counter lasts 79, 80 or 81 clocks. With a fixed-mode tick every 80 clocks, exactly one strobe falls in each 80-clock window.
- R4: In adaptive mode, a transition sampled at phase p counts as a late vote for p in 1..39 and as an early vote for p in 40..79. Phase 0 gives no vote. When the net count reaches 4 in one direction, the count clears and the pending period becomes 81 (late) or 79 (early) clocks.
- R5: In adaptive mode with transitions exactly 80 clocks apart, the loop settles so that `samp_stb` pulses 40 cycles after each transition's sampling edge.
- R6: With transition spacing that is 81 or 79 clocks once every 60 symbols, the settled strobe stays 36 to 44 cycles after the last transition, and `locked` stays high.
- R7: `baud_clk` is high for the first 40 clocks of each period and low for the rest. In adaptive mode `samp_stb` coincides with the first low cycle.
- R8: At each period boundary, a period that held a transition and none with phase error beyond ±1 clock adds to a run count; a larger error clears the run. `locked` rises when the run reaches 16.
- R9: `locked` falls at the 64th consecutive period boundary with no transition.
- R10: A change of `mode_adapt` takes effect at the next period boundary. Until then, `tx_tick` is ignored while the loop is still in adaptive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 15.36 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_adapt | input | 1 | 1 = adaptive tracking, 0 = fixed offset from transmit tick |
| fix_offset | input | 7 | Fixed-mode strobe position in clocks after the boundary (0..78) |
| tx_tick | input | 1 | One-cycle pulse at the start of each local transmit baud |
| rx_edge | input | 1 | One-cycle pulse per transition of the sliced receive signal |
| samp_stb | output | 1 | One-cycle receive sampling strobe |
| baud_clk | output | 1 | Recovered baud clock, high for the first half of each period |
| locked | output | 1 | Loop lock indication |

## Verification
Fixed mode is tried with a regular transmit tick at offsets 0 and 78 plus random offsets, while random noise transitions are injected. This shows whether the strobe depends only on the tick and the offset. Adaptive mode starts from a random initial phase error, which separates convergence and lock acquisition from a loop that merely free-runs. Directed phase steps of +3 and -3 clocks then expose the vote threshold and the direction of each correction, cycle by cycle. Periodic ±1 spacing slips model a frequency offset and separate a tracking loop from one that drifts out of lock. A silent line and a mid-period mode switch with a misaligned tick check the loss timer and that mode changes wait for the boundary.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_LONG  = 2'd1,
    CORR_SHORT = 2'd2
  } corr_e;
endpackage

// File: rtl/bdr_phase_ctr.sv
module bdr_phase_ctr
  import bdr_pkg::*;
#(
  parameter int PERIOD = 80,
  parameter int PW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          resync,
  input  corr_e         corr,
  output logic [PW-1:0] ph,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST_NOM = PW'(PERIOD - 1);

  logic [PW-1:0] last_ph;

  // pending correction picks the length of the running period
  always_comb begin
    case (corr)
      CORR_LONG:  last_ph = LAST_NOM + 1'b1;
      CORR_SHORT: last_ph = LAST_NOM - 1'b1;
      default:    last_ph = LAST_NOM;
    endcase
  end

  assign wrap = (ph >= last_ph);

  always_ff @(posedge clk) begin
    if (rst)                 ph <= '0;
    else if (resync || wrap) ph <= '0;
    else                     ph <= ph + 1'b1;
  end
endmodule

// File: rtl/bdr_vote_filter.sv
module bdr_vote_filter
  import bdr_pkg::*;
#(
  parameter int PERIOD  = 80,
  parameter int PW      = 7,
  parameter int VOTE_TH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          edge_in,
  input  logic [PW-1:0] ph,
  input  logic          wrap,
  output corr_e         corr
);
  localparam int HALF = PERIOD / 2;
  localparam int AW   = $clog2(VOTE_TH) + 1;
  localparam logic signed [AW-1:0] TOP = AW'(VOTE_TH - 1);
  localparam logic signed [AW-1:0] BOT = -TOP;

  logic signed [AW-1:0] acc;
  logic late, early, hit_late, hit_early;

  assign late      = enable && edge_in && (ph != '0) && (ph < PW'(HALF));
  assign early     = enable && edge_in && (ph >= PW'(HALF));
  assign hit_late  = late  && (acc == TOP);
  assign hit_early = early && (acc == BOT);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      acc  <= '0;
      corr <= CORR_NONE;
    end else if (hit_late) begin
      acc  <= '0;
      corr <= CORR_LONG;
    end else if (hit_early) begin
      acc  <= '0;
      corr <= CORR_SHORT;
    end else begin
      if (late)       acc <= acc + 1'b1;
      else if (early) acc <= acc - 1'b1;
      if (wrap) corr <= CORR_NONE;
    end
  end
endmodule

// File: rtl/bdr_lock_mon.sv
module bdr_lock_mon #(
  parameter int PERIOD = 80,
  parameter int PW     = 7,
  parameter int LOCK_N = 16,
  parameter int LOSS_N = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_in,
  input  logic [PW-1:0] ph,
  input  logic          boundary,
  output logic          locked
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int SW = $clog2(LOSS_N + 1);

  logic [GW-1:0] good_run;
  logic [SW-1:0] silent;
  logic seen_e, seen_b, small_err, e_any, b_any;

  assign small_err = (ph == '0) || (ph == PW'(1)) || (ph >= PW'(PERIOD - 1));
  assign e_any     = seen_e | edge_in;
  assign b_any     = seen_b | (edge_in & ~small_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      good_run <= '0;
      silent   <= '0;
      seen_e   <= 1'b0;
      seen_b   <= 1'b0;
      locked   <= 1'b0;
    end else if (boundary) begin
      seen_e <= 1'b0;
      seen_b <= 1'b0;
      if (e_any)                     silent <= '0;
      else if (silent != SW'(LOSS_N)) silent <= silent + 1'b1;
      if (!e_any && silent == SW'(LOSS_N - 1)) begin
        locked   <= 1'b0;
        good_run <= '0;
      end else if (b_any) begin
        good_run <= '0;
      end else if (e_any) begin
        if (good_run != GW'(LOCK_N))     good_run <= good_run + 1'b1;
        if (good_run == GW'(LOCK_N - 1)) locked   <= 1'b1;
      end
    end else begin
      seen_e <= e_any;
      seen_b <= b_any;
    end
  end
endmodule

// File: rtl/baud_rec_dpll.sv
module baud_rec_dpll
  import bdr_pkg::*;
#(
  parameter int PERIOD  = 80,
  parameter int VOTE_TH = 4,
  parameter int LOCK_N  = 16,
  parameter int LOSS_N  = 64,
  parameter int PW      = $clog2(PERIOD + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_adapt,
  input  logic [PW-1:0] fix_offset,
  input  logic          tx_tick,
  input  logic          rx_edge,
  output logic          samp_stb,
  output logic          baud_clk,
  output logic          locked
);
  localparam int HALF = PERIOD / 2;

  logic          mode_q;
  logic          resync, wrap, boundary;
  logic [PW-1:0] ph;
  corr_e         corr;

  assign resync   = !mode_q && tx_tick;
  assign boundary = wrap || resync;

  bdr_phase_ctr #(.PERIOD(PERIOD), .PW(PW)) u_ctr (
    .clk(clk), .rst(rst), .resync(resync), .corr(corr), .ph(ph), .wrap(wrap)
  );

  bdr_vote_filter #(.PERIOD(PERIOD), .PW(PW), .VOTE_TH(VOTE_TH)) u_vote (
    .clk(clk), .rst(rst), .enable(mode_q), .edge_in(rx_edge), .ph(ph),
    .wrap(wrap), .corr(corr)
  );

  bdr_lock_mon #(.PERIOD(PERIOD), .PW(PW), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_lock (
    .clk(clk), .rst(rst), .edge_in(rx_edge), .ph(ph), .boundary(boundary),
    .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= mode_adapt;
      samp_stb <= 1'b0;
      baud_clk <= 1'b0;
    end else begin
      if (boundary) mode_q <= mode_adapt;
      samp_stb <= mode_q ? (ph == PW'(HALF)) : (ph == fix_offset);
      baud_clk <= (ph < PW'(HALF));
    end
  end
endmodule

// File: rtl/bdr_dpll_chk.sv
module bdr_dpll_chk #(
  parameter int PERIOD = 80,
  parameter int PW     = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          samp_stb,
  input logic          baud_clk,
  input logic          locked,
  input logic          mode_q,
  input logic [PW-1:0] ph,
  input logic          resync
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!samp_stb && !baud_clk && !locked)); // R1

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    samp_stb |=> !samp_stb); // R3

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    ph <= PW'(PERIOD)); // R3

  AST_WRAP_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (ph == '0 && $past(ph) != '0 && !$past(resync)) |-> ($past(ph) >= PW'(PERIOD - 2))); // R3

  AST_MID_STROBE: assert property (@(posedge clk) disable iff (rst)
    (samp_stb && mode_q && $past(mode_q)) |-> $fell(baud_clk)); // R7
endmodule

bind baud_rec_dpll bdr_dpll_chk #(.PERIOD(PERIOD), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .samp_stb(samp_stb), .baud_clk(baud_clk),
  .locked(locked), .mode_q(mode_q), .ph(ph), .resync(resync)
);

// File: tb/test_baud_rec_dpll.sv
`timescale 1ns/1ps
module test_baud_rec_dpll;
  localparam int PER = 80;

  logic clk = 1'b0, rst = 1'b1, mode_adapt = 1'b0, tx_tick = 1'b0, rx_edge = 1'b0;
  logic [6:0] fix_offset = '0;
  logic samp_stb, baud_clk, locked;

  baud_rec_dpll i_baud_rec_dpll (
    .clk(clk), .rst(rst), .mode_adapt(mode_adapt), .fix_offset(fix_offset),
    .tx_tick(tx_tick), .rx_edge(rx_edge), .samp_stb(samp_stb),
    .baud_clk(baud_clk), .locked(locked)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;

  // stimulus controls and monitor statistics
  bit edge_en = 0, tick_en = 0, edge_noise = 0, step_arm = 0;
  int egap = 0, tgap = 0, drift_every = 0, drift_dir = 0, drift_ctr = 0, edge_extra = 0;
  int last_edge = -100000, last_tick = -100000;
  int dmin, dmax, tmin, tmax, nstb, hi_cnt;
  int step_idx = 99;
  int dl [5];

  task automatic clear_stats();
    dmin = 1000000; dmax = -1000000; tmin = 1000000; tmax = -1000000;
    nstb = 0; hi_cnt = 0;
  endtask

  always @(negedge clk) begin
    int d, t, g;
    if (samp_stb) begin
      nstb++;
      d = cyc - last_edge;
      t = cyc - last_tick;
      if (d < dmin) dmin = d;
      if (d > dmax) dmax = d;
      if (t < tmin) tmin = t;
      if (t > tmax) tmax = t;
      if (step_idx < 5) begin
        dl[step_idx] = d;
        step_idx++;
      end
    end
    if (baud_clk) hi_cnt++;
    rx_edge = 1'b0;
    tx_tick = 1'b0;
    if (edge_en) begin
      if (egap == 0) begin
        rx_edge = 1'b1;
        last_edge = cyc + 1;
        if (step_arm) begin
          step_idx = 0;
          step_arm = 0;
        end
        g = PER;
        drift_ctr++;
        if (drift_every > 0 && drift_ctr >= drift_every) begin
          g += drift_dir;
          drift_ctr = 0;
        end
        if (edge_extra != 0) step_arm = 1;
        g += edge_extra;
        edge_extra = 0;
        egap = g - 1;
      end else begin
        egap--;
      end
    end else if (edge_noise && $urandom_range(0, 9) == 0) begin
      rx_edge = 1'b1;
    end
    if (tick_en) begin
      if (tgap == 0) begin
        tx_tick = 1'b1;
        last_tick = cyc + 1;
        tgap = PER - 1;
      end else begin
        tgap--;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int offs [6];
    int s0;
    seed = $urandom(32'd4711);
    clear_stats();

    // R1: reset state
    tick_wait(4);
    chk("R1 samp_stb in reset", samp_stb, 0);
    chk("R1 baud_clk in reset", baud_clk, 0);
    chk("R1 locked in reset", locked, 0);

    // R2/R3/R7: fixed mode with noise transitions
    rst = 1'b0;
    tick_en = 1; tgap = 5; edge_noise = 1;
    offs[0] = 0; offs[1] = 78;
    for (int i = 2; i < 6; i++) offs[i] = $urandom_range(1, 77);
    for (int i = 0; i < 6; i++) begin
      fix_offset = 7'(offs[i]);
      tick_wait(3 * PER);
      clear_stats();
      tick_wait(4 * PER);
      chk("R2 fixed strobe after tick (min)", tmin, offs[i] + 1);
      chk("R2 fixed strobe after tick (max)", tmax, offs[i] + 1);
      chk("R3 one strobe per 80 clocks", nstb, 4);
      chk("R7 baud_clk high 40 of 80", hi_cnt, 160);
    end

    // adaptive mode from a random phase error
    edge_noise = 0; tick_en = 0;
    rst = 1'b1; mode_adapt = 1'b1;
    tick_wait(3);
    rst = 1'b0;
    egap = $urandom_range(10, 30);
    edge_en = 1;
    tick_wait(10 * PER);
    chk("R8 not locked during large error", locked, 0);
    tick_wait(300 * PER);
    chk("R8 locked after settling", locked, 1);
    clear_stats();
    tick_wait(20 * PER);
    chk("R5 settled strobe after edge (min)", dmin, 40);
    chk("R5 settled strobe after edge (max)", dmax, 40);

    // R4: late step of 3 clocks
    edge_extra = 3;
    tick_wait(8 * PER);
    for (int i = 0; i < 4; i++) chk("R4 late votes below threshold", dl[i], 37);
    chk("R4 late correction after 4 votes", dl[4], 38);
    tick_wait(30 * PER);

    // R4: early step of 3 clocks
    edge_extra = -3;
    tick_wait(8 * PER);
    for (int i = 0; i < 3; i++) chk("R4 early votes below threshold", dl[i], 43);
    chk("R4 early correction after 4 votes", dl[4], 42);
    tick_wait(30 * PER);

    // R6: frequency offset in both directions
    for (int dir = -1; dir <= 1; dir += 2) begin
      drift_every = 60; drift_dir = dir; drift_ctr = 0;
      tick_wait(5 * PER);
      clear_stats();
      tick_wait(200 * PER);
      chk("R6 strobe window low edge", int'(dmin >= 36), 1);
      chk("R6 strobe window high edge", int'(dmax <= 44), 1);
      chk("R6 lock held under offset", locked, 1);
    end

    // R9: loss of lock on a silent line
    drift_every = 0;
    tick_wait(20 * PER);
    edge_en = 0;
    tick_wait(60 * PER);
    chk("R9 still locked after 60 silent periods", locked, 1);
    tick_wait(8 * PER);
    chk("R9 lock lost after 64 silent periods", locked, 0);

    // R10: mode change waits for the boundary, tick ignored until then
    do begin
      @(posedge clk); #1;
    end while (!samp_stb);
    s0 = cyc;
    tick_wait(10);
    fix_offset = 7'd20;
    mode_adapt = 1'b0;
    tick_en = 1; tgap = 0;
    do begin
      @(posedge clk); #1;
    end while (!samp_stb);
    chk("R10 first strobe after switch (boundary+20)", cyc - s0, 60);
    tick_wait(3 * PER);
    clear_stats();
    tick_wait(2 * PER);
    chk("R10 fixed mode active after boundary", tmin, 21);
    chk("R10 fixed mode stable", tmax, 21);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule